// File: doc/BRIEF.md
# Master Clock Select and Divide Controller

This block derives two clock enables from four free-running source tick inputs: a processor clock enable and a slower master clock enable that feeds peripherals and memory. One source is picked, its ticks pass through a power-of-two prescaler to form the processor clock, and a second small divider turns the processor clock into the master clock. All clocks are modelled as single-cycle enable pulses inside one system clock domain.

Software programs the block through a plain register write port with a combinational read port. A new configuration is not applied at once. It waits for the end of the current master clock period, then for a short settling delay counted in ticks of the new source. A status bit shows when the new clock is running and can drive an interrupt. A write that changes the source and the master divider together is refused and flagged. A separate register puts the processor clock into idle while the master clock keeps running. Any wake-up interrupt restarts it.

Top module: `mclk_unit`

## Requirements
- R1: After reset the configuration register (address 0) reads 0, meaning slow source and divide by 1 on both stages. The status register (address 1) reads 1, which is ready set and error clear. The idle register (address 3) reads 1, meaning the processor clock is running.
- R2: Configuration field `src` (bits 1:0) selects the source tick input `srcTick[src]`. Code 0 is slow, 1 is main oscillator, 2 is PLL A and 3 is USB PLL. Address 0 reads back the last accepted configuration.
- R3: Prescaler field `pres` (bits 6:4): codes 0 to 6 divide the selected ticks by 1, 2, 4, 8, 16, 32 and 64, and code 7 divides by 1. `procClkEn` pulses on every Nth selected tick.
- R4: Master divider field `mdiv` (bits 9:8): codes 0, 1, 2 and 3 divide by 1, 2, 4 and 3. Every `mstClkEn` pulse falls in a cycle where the processor clock ticks, and there is one for every N processor ticks.
- R5: An accepted write to address 0 clears the ready bit (address 1 bit 0) in the next cycle.
- R6: A new configuration is applied at the next master clock boundary of the old one, with both counters restarting. Ready sets after 2 further ticks of the new source, unless a new accepted write arrives first.
- R7: A write to address 0 whose `src` and `mdiv` both differ from the stored configuration is ignored and sets a sticky error bit (address 1 bit 1). Writing address 1 with bit 1 set clears the error bit.
- R8: `irq` is high while the ready bit and the interrupt enable (address 2 bit 0) are both 1.
- R9: Any write to address 3 stops `procClkEn` while `mstClkEn` keeps running. A cycle with `wakeIrq` high restarts it, and wake takes priority. Address 3 bit 0 reads whether the processor clock is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcTick | input | 4 | Source tick enables: slow, main, PLL A, USB PLL |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address for read and write |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data of the addressed register |
| wakeIrq | input | 1 | OR of wake-up interrupts, leaves idle |
| procClkEn | output | 1 | Processor clock enable |
| mstClkEn | output | 1 | Master clock enable |
| irq | output | 1 | Ready interrupt |

## Verification
The hardest case to reach is a configuration write that lands while an earlier change is still pending or settling. Here the later write must win, and no stale switch or ready rise may leak through. The stimulus reaches it by issuing two accepted writes on consecutive cycles. It also runs slow sources with long divide ratios, so that writes fall inside the wait for the master clock boundary. A rejected combined write is issued straight after reset, when both fields differ from their reset values. A cycle-by-cycle reference model compares the enables, the interrupt and the read port on every clock.

// File: rtl/mclk_pkg.sv
package mclk_pkg;
  localparam int SRC_CNT   = 4;
  localparam int SRC_W     = $clog2(SRC_CNT);
  localparam int PRES_W    = 3;
  localparam int MDIV_W    = 2;
  localparam int PRE_CNT_W = 6;
  localparam int ADDR_W    = 2;
  localparam int DATA_W    = 16;

  localparam int CFG_SRC_LSB  = 0;
  localparam int CFG_PRES_LSB = 4;
  localparam int CFG_MDIV_LSB = 8;
  localparam int STAT_RDY_BIT = 0;
  localparam int STAT_ERR_BIT = 1;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_IEN  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_IDLE = 2'd3;

  typedef struct packed {
    logic [MDIV_W-1:0] mdiv;
    logic [PRES_W-1:0] pres;
    logic [SRC_W-1:0]  src;
  } mclkCfg_t;

  typedef struct packed {
    logic     applyCfg;
    mclkCfg_t nextCfg;
  } mclkStrobe_t;

  typedef enum logic [1:0] {PH_STABLE, PH_WAIT_EDGE, PH_SYNC} mclkPhase_t;

  // terminal count of the prescaler: divide-by minus one
  function automatic logic [PRE_CNT_W-1:0] presLimit(input logic [PRES_W-1:0] code);
    logic [PRE_CNT_W:0] div;
    if (int'(code) <= PRE_CNT_W) div = (PRE_CNT_W+1)'(1) << code;
    else div = (PRE_CNT_W+1)'(1);
    return PRE_CNT_W'(div - 1'b1);
  endfunction

  function automatic logic [MDIV_W-1:0] mdivLimit(input logic [MDIV_W-1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      2'd2:    return 2'd3;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/mclk_divpath.sv
module mclk_divpath
  import mclk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [SRC_CNT-1:0] srcTick,
  input  mclkStrobe_t        strobe,
  output logic               selTick,
  output logic               procTick,
  output logic               mstTick
);
  mclkCfg_t              actCfg;
  logic [PRE_CNT_W-1:0]  preCnt;
  logic [MDIV_W-1:0]     mdCnt;
  logic [SRC_CNT-1:0]    selHit;

  for (genvar i = 0; i < SRC_CNT; i++) begin : g_sel
    assign selHit[i] = srcTick[i] && (actCfg.src == SRC_W'(i));
  end

  assign selTick  = |selHit;
  assign procTick = selTick && (preCnt == presLimit(actCfg.pres));
  assign mstTick  = procTick && (mdCnt == mdivLimit(actCfg.mdiv));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actCfg <= '0;
      preCnt <= '0;
      mdCnt  <= '0;
    end else if (strobe.applyCfg) begin
      actCfg <= strobe.nextCfg;
      preCnt <= '0;
      mdCnt  <= '0;
    end else if (selTick) begin
      preCnt <= procTick ? '0 : preCnt + 1'b1;
      if (procTick) mdCnt <= mstTick ? '0 : mdCnt + 1'b1;
    end
  end
endmodule

// File: rtl/mclk_regctl.sv
module mclk_regctl
  import mclk_pkg::*;
#(
  parameter int SYNC_TICKS = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              wakeIrq,
  input  logic              selTick,
  input  logic              mstTick,
  output mclkStrobe_t       strobe,
  output mclkCfg_t          cfgReq,
  output logic              readyFlag,
  output logic              errFlag,
  output logic              procEn,
  output logic              irq
);
  localparam int SYNC_W = $clog2(SYNC_TICKS + 1);

  mclkPhase_t        phase;
  logic [SYNC_W-1:0] syncCnt;
  logic              irqEn;
  mclkCfg_t          wrCfg;
  logic              cfgWr, clash, cfgAccept;
  logic              unusedWdata;

  assign wrCfg.src  = busWdata[CFG_SRC_LSB  +: SRC_W];
  assign wrCfg.pres = busWdata[CFG_PRES_LSB +: PRES_W];
  assign wrCfg.mdiv = busWdata[CFG_MDIV_LSB +: MDIV_W];
  assign unusedWdata = ^{busWdata[DATA_W-1:10], busWdata[7], busWdata[3:2]};

  assign cfgWr     = busWr && (busAddr == ADDR_CFG);
  assign clash     = (wrCfg.src != cfgReq.src) && (wrCfg.mdiv != cfgReq.mdiv);
  assign cfgAccept = cfgWr && !clash;

  assign strobe.applyCfg = (phase == PH_WAIT_EDGE) && mstTick && !cfgAccept;
  assign strobe.nextCfg  = cfgReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReq    <= '0;
      phase     <= PH_STABLE;
      syncCnt   <= '0;
      readyFlag <= 1'b1;
    end else if (cfgAccept) begin
      cfgReq    <= wrCfg;
      phase     <= PH_WAIT_EDGE;
      readyFlag <= 1'b0;
    end else begin
      case (phase)
        PH_WAIT_EDGE: if (mstTick) begin
          phase   <= PH_SYNC;
          syncCnt <= '0;
        end
        PH_SYNC: if (selTick) begin
          if (syncCnt == SYNC_W'(SYNC_TICKS - 1)) begin
            readyFlag <= 1'b1;
            phase     <= PH_STABLE;
          end else begin
            syncCnt <= syncCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
      irqEn   <= 1'b0;
      procEn  <= 1'b1;
    end else begin
      if (cfgWr && clash) errFlag <= 1'b1;
      else if (busWr && busAddr == ADDR_STAT && busWdata[STAT_ERR_BIT]) errFlag <= 1'b0;
      if (busWr && busAddr == ADDR_IEN) irqEn <= busWdata[0];
      if (wakeIrq) procEn <= 1'b1;
      else if (busWr && busAddr == ADDR_IDLE) procEn <= 1'b0;
    end
  end

  assign irq = readyFlag && irqEn;

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_CFG: begin
        busRdata[CFG_SRC_LSB  +: SRC_W]  = cfgReq.src;
        busRdata[CFG_PRES_LSB +: PRES_W] = cfgReq.pres;
        busRdata[CFG_MDIV_LSB +: MDIV_W] = cfgReq.mdiv;
      end
      ADDR_STAT: begin
        busRdata[STAT_RDY_BIT] = readyFlag;
        busRdata[STAT_ERR_BIT] = errFlag;
      end
      ADDR_IEN:  busRdata[0] = irqEn;
      default:   busRdata[0] = procEn;
    endcase
  end
endmodule

// File: rtl/mclk_unit.sv
module mclk_unit
  import mclk_pkg::*;
#(
  parameter int SYNC_TICKS = 2
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [SRC_CNT-1:0] srcTick,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic               wakeIrq,
  output logic               procClkEn,
  output logic               mstClkEn,
  output logic               irq
);
  mclkStrobe_t strobe;
  mclkCfg_t    cfgReq;
  logic        readyFlag, errFlag, procEn;
  logic        selTick, procTick, mstTick;

  mclk_regctl #(.SYNC_TICKS(SYNC_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .wakeIrq(wakeIrq),
    .selTick(selTick), .mstTick(mstTick), .strobe(strobe),
    .cfgReq(cfgReq), .readyFlag(readyFlag), .errFlag(errFlag),
    .procEn(procEn), .irq(irq)
  );

  mclk_divpath u_path (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .strobe(strobe),
    .selTick(selTick), .procTick(procTick), .mstTick(mstTick)
  );

  assign procClkEn = procTick && procEn;
  assign mstClkEn  = mstTick;
endmodule

// File: rtl/mclk_unit_sva.sv
module mclk_unit_sva
  import mclk_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input mclkCfg_t          cfgReq,
  input logic              readyFlag,
  input logic              errFlag,
  input logic              procTick,
  input logic              mstTick,
  input logic              procEn,
  input logic              procClkEn,
  input logic              irq,
  input logic              wakeIrq
);
  logic cfgWr, bothDiffer, acceptWr, unusedBits;
  assign cfgWr      = busWr && (busAddr == ADDR_CFG);
  assign bothDiffer = (busWdata[CFG_SRC_LSB +: SRC_W] != cfgReq.src) &&
                      (busWdata[CFG_MDIV_LSB +: MDIV_W] != cfgReq.mdiv);
  assign acceptWr   = cfgWr && !bothDiffer;
  assign unusedBits = ^{busWdata[DATA_W-1:10], busWdata[7:2], cfgReq.pres};

  AST_WRITE_CLEARS_READY: assert property (@(posedge clk) disable iff (!rstN) acceptWr |=> !readyFlag); // R5
  AST_READY_RISE_QUIET: assert property (@(posedge clk) disable iff (!rstN) $rose(readyFlag) |-> !$past(acceptWr)); // R6
  AST_CLASH_IGNORED: assert property (@(posedge clk) disable iff (!rstN) (cfgWr && bothDiffer) |=> ($stable(cfgReq) && errFlag)); // R7
  AST_MST_ON_PROC: assert property (@(posedge clk) disable iff (!rstN) mstTick |-> procTick); // R4
  AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN) irq |-> readyFlag); // R8
  AST_IDLE_STOPS: assert property (@(posedge clk) disable iff (!rstN) (busWr && busAddr == ADDR_IDLE && !wakeIrq) |=> !procEn); // R9
  AST_PROC_GATED: assert property (@(posedge clk) disable iff (!rstN) procClkEn |-> procEn); // R9
  AST_WAKE_RESUMES: assert property (@(posedge clk) disable iff (!rstN) wakeIrq |=> procEn); // R9
endmodule

bind mclk_unit mclk_unit_sva u_sva (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
  .cfgReq(cfgReq), .readyFlag(readyFlag), .errFlag(errFlag), .procTick(procTick),
  .mstTick(mstTick), .procEn(procEn), .procClkEn(procClkEn), .irq(irq), .wakeIrq(wakeIrq)
);

// File: tb/mclk_unit_test.sv
`timescale 1ns/1ps
module mclk_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  srcTick = '0;
  logic        busWr = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        wakeIrq = 1'b0;
  logic        procClkEn, mstClkEn, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mclk_unit uut (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .wakeIrq(wakeIrq),
    .procClkEn(procClkEn), .mstClkEn(mstClkEn), .irq(irq)
  );

  // ---------------- reference model ----------------
  int mActSrc, mActPre, mActMd, mPre, mMd, mPhase, mSync;
  int mCfgSrc, mCfgPre, mCfgMd, mReady, mErr, mIrqEn, mProcEn;

  function automatic int preDiv(int code);
    return (code <= 6) ? (1 << code) : 1;
  endfunction
  function automatic int mdDiv(int code);
    case (code) 0: return 1; 1: return 2; 2: return 4; default: return 3; endcase
  endfunction
  function automatic bit modelProc();
    return srcTick[mActSrc] && (mPre == preDiv(mActPre) - 1);
  endfunction
  function automatic bit modelMst();
    return modelProc() && (mMd == mdDiv(mActMd) - 1);
  endfunction
  function automatic int modelRead(int a);
    case (a)
      0: return (mCfgMd << 8) | (mCfgPre << 4) | mCfgSrc;
      1: return (mErr << 1) | mReady;
      2: return mIrqEn;
      default: return mProcEn;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mActSrc = 0; mActPre = 0; mActMd = 0; mPre = 0; mMd = 0; mPhase = 0; mSync = 0;
      mCfgSrc = 0; mCfgPre = 0; mCfgMd = 0; mReady = 1; mErr = 0; mIrqEn = 0; mProcEn = 1;
    end else begin
      bit sel, pT, mT, wrC, rej, acc;
      int nS, nP, nM;
      sel = srcTick[mActSrc];
      pT = modelProc();
      mT = modelMst();
      nS = busWdata[1:0]; nP = busWdata[6:4]; nM = busWdata[9:8];
      wrC = busWr && busAddr == 0;
      rej = wrC && nS != mCfgSrc && nM != mCfgMd;
      acc = wrC && !rej;
      if (mPhase == 1 && mT && !acc) begin
        mActSrc = mCfgSrc; mActPre = mCfgPre; mActMd = mCfgMd;
        mPre = 0; mMd = 0; mPhase = 2; mSync = 0;
      end else begin
        if (sel) begin
          mPre = pT ? 0 : mPre + 1;
          if (pT) mMd = mT ? 0 : mMd + 1;
        end
        if (mPhase == 2 && sel) begin
          if (mSync == 1) begin mReady = 1; mPhase = 0; end
          else mSync++;
        end
      end
      if (acc) begin mCfgSrc = nS; mCfgPre = nP; mCfgMd = nM; mReady = 0; mPhase = 1; end
      if (rej) mErr = 1;
      else if (busWr && busAddr == 1 && busWdata[1]) mErr = 0;
      if (busWr && busAddr == 2) mIrqEn = busWdata[0];
      if (wakeIrq) mProcEn = 1;
      else if (busWr && busAddr == 3) mProcEn = 0;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // every-cycle comparison, mid-cycle
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R3", "procClkEn", procClkEn, modelProc() && mProcEn);
      check("R4", "mstClkEn", mstClkEn, modelMst());
      check("R8", "irq", irq, mIrqEn && mReady);
      case (busAddr)
        2'd0: check("R2", "cfg readback", busRdata, modelRead(0));
        2'd1: check("R6", "status readback", busRdata, modelRead(1));
        2'd2: check("R8", "irq enable readback", busRdata, modelRead(2));
        default: check("R9", "idle readback", busRdata, modelRead(3));
      endcase
    end
  end

  // source tick generator: slow /7, main /3, PLL A every cycle, USB PLL /2
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #2;
      cyc++;
      srcTick[0] = (cyc % 7) == 0;
      srcTick[1] = (cyc % 3) == 0;
      srcTick[2] = 1'b1;
      srcTick[3] = (cyc % 2) == 1;
    end
  end

  function automatic logic [15:0] mk(int s, int p, int m);
    return 16'((m << 8) | (p << 4) | s);
  endfunction

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(posedge clk); #2;
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #2;
    busWr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(posedge clk); #2;
    busAddr = a;
    @(negedge clk);
    d = busRdata;
  endtask

  task automatic waitReady(string req);
    int n = 0;
    @(posedge clk); #2;
    busAddr = 2'd1;
    @(negedge clk);
    while (!busRdata[0] && n < 5000) begin
      @(negedge clk); n++;
    end
    check(req, "ready reached", busRdata[0], 1);
  endtask

  task automatic countPulses(int n, output int procN, output int mstN);
    procN = 0; mstN = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (procClkEn) procN++;
      if (mstClkEn) mstN++;
    end
  endtask

  initial begin
    logic [15:0] d;
    int pN, mN;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    rd(0, d); check("R1", "reset cfg", d, 0);
    rd(1, d); check("R1", "reset status", d, 1);
    rd(3, d); check("R1", "reset idle reg", d, 1);

    wr(2, 16'h1);
    rd(2, d); check("R8", "irq enable set", d, 1);
    check("R8", "irq high when ready", irq, 1);

    // combined source+divider change refused
    wr(0, mk(2, 0, 3));
    rd(1, d); check("R7", "error set, ready kept", d, 3);
    rd(0, d); check("R7", "cfg unchanged", d, 0);
    wr(1, 16'h2);
    rd(1, d); check("R7", "error cleared", d, 1);

    wr(0, mk(2, 0, 0));
    rd(1, d); check("R5", "ready cleared after write", d[0], 0);
    waitReady("R6");
    rd(0, d); check("R2", "cfg readback pll a", d, mk(2, 0, 0));

    wr(0, mk(2, 0, 3));
    waitReady("R6");
    countPulses(60, pN, mN);
    check("R4", "divide by 3 count", mN, 20);

    wr(0, mk(2, 2, 1));
    waitReady("R6");
    countPulses(80, pN, mN);
    check("R3", "prescale 4 count", pN, 20);
    check("R4", "divide by 2 count", mN, 10);

    wr(0, mk(2, 7, 1));
    waitReady("R6");
    countPulses(40, pN, mN);
    check("R3", "reserved code divides by 1", pN, 40);

    wr(0, mk(2, 6, 2));
    waitReady("R6");
    wr(0, mk(1, 1, 2));
    waitReady("R6");
    countPulses(60, pN, mN);
    check("R2", "main source prescale 2", pN, 10);
    wr(0, mk(3, 0, 2));
    waitReady("R6");
    wr(0, mk(0, 0, 2));
    waitReady("R6");
    wr(0, mk(0, 0, 0));
    waitReady("R6");

    // back-to-back accepted writes: the later one wins
    @(posedge clk); #2;
    busWr = 1'b1; busAddr = 2'd0; busWdata = mk(0, 1, 0);
    @(posedge clk); #2;
    busWdata = mk(0, 2, 0);
    @(posedge clk); #2;
    busWr = 1'b0;
    rd(1, d); check("R5", "ready low after burst", d[0], 0);
    waitReady("R6");
    rd(0, d); check("R2", "last write kept", d, mk(0, 2, 0));

    wr(0, mk(2, 0, 0));
    waitReady("R6");
    wr(3, 16'h0);
    countPulses(50, pN, mN);
    check("R9", "idle stops processor clock", pN, 0);
    check("R9", "master clock keeps running", mN, 50);
    rd(3, d); check("R9", "idle readback", d, 0);
    @(posedge clk); #2 wakeIrq = 1'b1;
    @(posedge clk); #2 wakeIrq = 1'b0;
    countPulses(20, pN, mN);
    check("R9", "wake restores processor clock", pN, 20);

    repeat (5) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule